// File: doc/BRIEF.md
# DRAM DLL State and Lock-Wait Tracker

This block follows the state of the delay-locked loop inside a DDR-style SDRAM, or the copy of that state a memory controller keeps on its side. It takes decoded command strobes (a mode-register write carrying the DLL-disable bit, a DLL reset, self-refresh entry and exit, read, synchronous ODT and write) together with the sampled CKE level and the write-termination setting. From them it works out whether the DLL is running and whether it has finished locking.

Each time the DLL is switched on it must go through a lock window of `TDLLK` clock cycles. This covers a mode-register enable, an explicit DLL reset and the automatic re-enable when self-refresh ends. During that window, reads and synchronous ODT commands are not allowed. Writes are not allowed either when write termination is active. The block does not stop such commands. It raises a one-cycle flag for each one and counts it. CKE must stay high for the whole window, and if it goes low the block sets a sticky error.

The controlling state machine has four states. `DLL_OFF` is the reset state and the DLL-disabled mode. `DLL_LOCKING` is the lock window. `DLL_LOCKED` is normal operation. `DLL_SREF` means the DLL was switched off automatically by self-refresh. The transitions are:
- enable: OFF to LOCKING.
- disable: LOCKING or LOCKED to OFF.
- relock: LOCKING or LOCKED back into LOCKING on a DLL reset.
- lock_done: LOCKING to LOCKED.
- sref_in: LOCKING or LOCKED to SREF.
- sref_out: SREF to LOCKING.

Top module: `dll_lock_tracker`

## Requirements
- R1: After reset, dll_on, dll_locked, early_cmd_viol, cke_drop_err and viol_count are all 0, and the state is DLL_OFF.
- R2: An MR1 write (mr1_wr=1) with mr1_dll_dis=0 in DLL_OFF enables the DLL, so dll_on is 1 and dll_locked is 0 on the next cycle. An MR1 write with mr1_dll_dis=1 in LOCKING or LOCKED turns the DLL off, so dll_on is 0 on the next cycle.
- R3: sref_enter while the DLL is on drives dll_on low on the next cycle. sref_enter in DLL_OFF has no effect. In DLL_SREF only sref_exit acts, and it returns dll_on=1 with dll_locked=0 and starts a new window.
- R4: dll_locked rises exactly TDLLK clock edges after the edge that samples the window-starting event. A dll_rst_cmd in LOCKING or LOCKED restarts the full window, including on the last cycle of a window.
- R5: When several control strobes arrive in the same cycle, sref_enter wins over an MR1 write, and an MR1 write wins over dll_rst_cmd.
- R6: A read (rd_cmd) or ODT command (odt_cmd) sampled during the lock window makes early_cmd_viol 1 for exactly the next cycle. The same commands outside the window leave it at 0.
- R7: A write (wr_cmd) sampled during the window raises early_cmd_viol only if rtt_wr_sel is nonzero. The value 0 means write termination is off.
- R8: cke=0 sampled during the window sets cke_drop_err from the next cycle until reset. cke=0 outside the window has no effect.
- R9: viol_count goes up by one for each violation pulse and holds at 2^CNT_W-1 once it reaches that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mr1_wr | input | 1 | Mode-register-1 write strobe |
| mr1_dll_dis | input | 1 | DLL-disable bit carried by the MR1 write (1 = off) |
| dll_rst_cmd | input | 1 | DLL reset command |
| sref_enter | input | 1 | Self-refresh entry |
| sref_exit | input | 1 | Self-refresh exit |
| rd_cmd | input | 1 | Read command |
| odt_cmd | input | 1 | Synchronous ODT command |
| wr_cmd | input | 1 | Write command |
| rtt_wr_sel | input | 2 | Write termination setting, 0 = off |
| cke | input | 1 | Sampled CKE level |
| dll_on | output | 1 | DLL is running |
| dll_locked | output | 1 | Lock window complete |
| early_cmd_viol | output | 1 | One-cycle pulse for a command issued inside the window |
| cke_drop_err | output | 1 | Sticky flag for CKE low inside the window |
| viol_count | output | CNT_W | Saturating count of violation pulses |

## Verification
The hardest case to reach from the ports is a DLL reset that lands on the final cycle of a lock window. At that edge the timer's expiry and the reload compete, and the window must restart rather than end. The bench gets there directly: it counts TDLLK-1 idle cycles after an enable and then presents the reset. A priority case is also driven on purpose, with self-refresh entry, an MR1 disable and a DLL reset all arriving in one cycle. Random traffic from a fixed seed then mixes all strobes against a cycle-level reference model kept in the bench.

// File: rtl/dll_trk_pkg.sv
package dll_trk_pkg;
    typedef enum logic [1:0] {
        DLL_OFF     = 2'd0,
        DLL_LOCKING = 2'd1,
        DLL_LOCKED  = 2'd2,
        DLL_SREF    = 2'd3
    } dll_state_e;
endpackage

// File: rtl/dll_mode_fsm.sv
module dll_mode_fsm
    import dll_trk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mr1_wr,
    input  logic       mr1_dll_dis,
    input  logic       dll_rst_cmd,
    input  logic       sref_enter,
    input  logic       sref_exit,
    input  logic       lock_expire,
    output dll_state_e state,
    output logic       load_timer,
    output logic       dll_on,
    output logic       dll_locked
);
    dll_state_e nxt;

    // next-state and timer-load decision
    always_comb begin
        nxt        = state;
        load_timer = 1'b0;
        unique case (state)
            DLL_OFF: begin
                if (mr1_wr && !mr1_dll_dis) begin
                    nxt        = DLL_LOCKING;      // enable
                    load_timer = 1'b1;
                end
            end
            DLL_LOCKING, DLL_LOCKED: begin
                if (sref_enter) begin
                    nxt = DLL_SREF;                 // sref_in
                end else if (mr1_wr && mr1_dll_dis) begin
                    nxt = DLL_OFF;                  // disable
                end else if (dll_rst_cmd) begin
                    nxt        = DLL_LOCKING;       // relock
                    load_timer = 1'b1;
                end else if (state == DLL_LOCKING && lock_expire) begin
                    nxt = DLL_LOCKED;               // lock_done
                end
            end
            DLL_SREF: begin
                if (sref_exit) begin
                    nxt        = DLL_LOCKING;       // sref_out
                    load_timer = 1'b1;
                end
            end
            default: nxt = DLL_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= DLL_OFF;
        else        state <= nxt;
    end

    always_comb begin
        dll_on     = (state == DLL_LOCKING) || (state == DLL_LOCKED);
        dll_locked = (state == DLL_LOCKED);
    end

    assert_sref_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sref_enter && dll_on) |=> !dll_on);
    assert_sref_relock_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == DLL_SREF && sref_exit) |=> (dll_on && !dll_locked));
    assert_lock_from_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dll_locked) |-> $past(state == DLL_LOCKING && lock_expire));
    assert_disable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (dll_on && mr1_wr && mr1_dll_dis) |=> !dll_locked);
endmodule

// File: rtl/dll_lock_timer.sv
module dll_lock_timer #(
    parameter int TDLLK = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic active,
    output logic expire
);
    localparam int CW = $clog2(TDLLK + 1);
    localparam logic [CW-1:0] START = CW'(TDLLK);

    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (!rst_n)                    remain <= '0;
        else if (load)                 remain <= START;
        else if (!active)              remain <= '0;
        else if (remain != '0)         remain <= remain - 1'b1;
    end

    assign expire = active && (remain == CW'(1));

    assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (remain == START));
    assert_count_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !load && remain > CW'(1)) |=> (remain == $past(remain) - 1'b1));
endmodule

// File: rtl/dll_cmd_monitor.sv
module dll_cmd_monitor #(
    parameter int CNT_W   = 8,
    parameter int RTT_W   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             window,
    input  logic             rd_cmd,
    input  logic             odt_cmd,
    input  logic             wr_cmd,
    input  logic [RTT_W-1:0] rtt_wr_sel,
    input  logic             cke,
    output logic             viol,
    output logic             cke_err,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic early_hit;
    assign early_hit = window && (rd_cmd || odt_cmd || (wr_cmd && (rtt_wr_sel != '0)));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            viol    <= 1'b0;
            cke_err <= 1'b0;
            count   <= '0;
        end else begin
            viol <= early_hit;
            if (window && !cke) cke_err <= 1'b1;
            if (viol && count != CNT_MAX) count <= count + 1'b1;
        end
    end

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cke_err |=> cke_err);
    assert_count_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (viol && count != CNT_MAX) |=> (count == $past(count) + 1'b1));
    assert_count_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!viol) |=> $stable(count));
endmodule

// File: rtl/dll_lock_tracker.sv
module dll_lock_tracker
    import dll_trk_pkg::*;
#(
    parameter int TDLLK = 512,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mr1_wr,
    input  logic             mr1_dll_dis,
    input  logic             dll_rst_cmd,
    input  logic             sref_enter,
    input  logic             sref_exit,
    input  logic             rd_cmd,
    input  logic             odt_cmd,
    input  logic             wr_cmd,
    input  logic [1:0]       rtt_wr_sel,
    input  logic             cke,
    output logic             dll_on,
    output logic             dll_locked,
    output logic             early_cmd_viol,
    output logic             cke_drop_err,
    output logic [CNT_W-1:0] viol_count
);
    dll_state_e state;
    logic       load_timer;
    logic       lock_expire;
    logic       in_window;

    assign in_window = (state == DLL_LOCKING);

    dll_mode_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .mr1_wr     (mr1_wr),
        .mr1_dll_dis(mr1_dll_dis),
        .dll_rst_cmd(dll_rst_cmd),
        .sref_enter (sref_enter),
        .sref_exit  (sref_exit),
        .lock_expire(lock_expire),
        .state      (state),
        .load_timer (load_timer),
        .dll_on     (dll_on),
        .dll_locked (dll_locked)
    );

    dll_lock_timer #(.TDLLK(TDLLK)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load_timer),
        .active(in_window),
        .expire(lock_expire)
    );

    dll_cmd_monitor #(.CNT_W(CNT_W), .RTT_W(2)) u_mon (
        .clk       (clk),
        .rst_n     (rst_n),
        .window    (in_window),
        .rd_cmd    (rd_cmd),
        .odt_cmd   (odt_cmd),
        .wr_cmd    (wr_cmd),
        .rtt_wr_sel(rtt_wr_sel),
        .cke       (cke),
        .viol      (early_cmd_viol),
        .cke_err   (cke_drop_err),
        .count     (viol_count)
    );

    assert_read_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dll_on && !dll_locked && (rd_cmd || odt_cmd)) |=> early_cmd_viol);
    assert_no_flag_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!dll_on || dll_locked) |=> !early_cmd_viol);
    assert_wr_no_rtt_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && rtt_wr_sel == 2'd0 && !rd_cmd && !odt_cmd) |=> !early_cmd_viol);
    assert_cke_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dll_on && !dll_locked && !cke) |=> cke_drop_err);
endmodule

// File: tb/sim_dll_lock_tracker.sv
`timescale 1ns/1ps
module sim_dll_lock_tracker;
    localparam int T  = 24;
    localparam int CW = 4;
    localparam int MAXC = (1 << CW) - 1;
    localparam int S_OFF = 0, S_LCK = 1, S_ON = 2, S_SR = 3;

    logic clk = 1'b0;
    logic rst_n;
    logic mr1_wr, mr1_dll_dis, dll_rst_cmd, sref_enter, sref_exit;
    logic rd_cmd, odt_cmd, wr_cmd, cke;
    logic [1:0] rtt_wr_sel;
    logic dll_on, dll_locked, early_cmd_viol, cke_drop_err;
    logic [CW-1:0] viol_count;

    int tests = 0, fails = 0;
    bit done = 0;
    int m_st, m_tmr, m_cnt;
    bit m_viol, m_err;

    always #2.5 clk = ~clk;

    dll_lock_tracker #(.TDLLK(T), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .mr1_wr(mr1_wr), .mr1_dll_dis(mr1_dll_dis),
        .dll_rst_cmd(dll_rst_cmd), .sref_enter(sref_enter), .sref_exit(sref_exit),
        .rd_cmd(rd_cmd), .odt_cmd(odt_cmd), .wr_cmd(wr_cmd), .rtt_wr_sel(rtt_wr_sel),
        .cke(cke), .dll_on(dll_on), .dll_locked(dll_locked),
        .early_cmd_viol(early_cmd_viol), .cke_drop_err(cke_drop_err),
        .viol_count(viol_count));

    task automatic check(string tag, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic idle();
        mr1_wr = 0; mr1_dll_dis = 0; dll_rst_cmd = 0; sref_enter = 0; sref_exit = 0;
        rd_cmd = 0; odt_cmd = 0; wr_cmd = 0; rtt_wr_sel = 0; cke = 1;
    endtask

    function automatic void model_update();
        if (!rst_n) begin
            m_st = S_OFF; m_tmr = 0; m_cnt = 0; m_viol = 0; m_err = 0;
            return;
        end
        if (m_viol && m_cnt != MAXC) m_cnt++;
        m_viol = (m_st == S_LCK) && (rd_cmd || odt_cmd || (wr_cmd && rtt_wr_sel != 0));
        if (m_st == S_LCK && !cke) m_err = 1;
        case (m_st)
            S_OFF: if (mr1_wr && !mr1_dll_dis) begin m_st = S_LCK; m_tmr = T; end
            S_LCK, S_ON: begin
                if (sref_enter) m_st = S_SR;
                else if (mr1_wr && mr1_dll_dis) m_st = S_OFF;
                else if (dll_rst_cmd) begin m_st = S_LCK; m_tmr = T; end
                else if (m_st == S_LCK) begin
                    if (m_tmr == 1) m_st = S_ON;
                    m_tmr--;
                end
            end
            default: if (sref_exit) begin m_st = S_LCK; m_tmr = T; end
        endcase
    endfunction

    task automatic step();
        @(posedge clk);
        model_update();
        @(negedge clk);
        check("R2 R3 dll_on", dll_on, (m_st == S_LCK || m_st == S_ON));
        check("R4 dll_locked", dll_locked, (m_st == S_ON));
        check("R6 R7 violation pulse", early_cmd_viol, m_viol);
        check("R8 cke error", cke_drop_err, m_err);
        check("R9 violation count", viol_count, m_cnt);
    endtask

    task automatic do_reset();
        idle(); rst_n = 0;
        step(); step();
        rst_n = 1;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        idle(); rst_n = 0;
        @(negedge clk);
        do_reset();
        check("R1 reset dll_on", dll_on, 0);
        check("R1 reset locked", dll_locked, 0);
        check("R1 reset count", viol_count, 0);
        check("R1 reset err", cke_drop_err, 0);

        // R3: self-refresh entry in OFF is ignored
        sref_enter = 1; step(); idle();
        check("R3 sref in off ignored", dll_on, 0);

        // R2: enable
        mr1_wr = 1; step(); idle();
        check("R2 enable dll_on", dll_on, 1);
        check("R2 enable not locked", dll_locked, 0);
        // R6: read in window
        rd_cmd = 1; step(); idle();
        check("R6 read in window", early_cmd_viol, 1);
        step();
        check("R6 pulse one cycle", early_cmd_viol, 0);
        // R7: write with rtt off, then on
        wr_cmd = 1; rtt_wr_sel = 0; step(); idle();
        check("R7 write rtt off", early_cmd_viol, 0);
        wr_cmd = 1; rtt_wr_sel = 2; step(); idle();
        check("R7 write rtt on", early_cmd_viol, 1);
        // R4: lock after T edges total (4 used)
        repeat (T - 5) step();
        check("R4 not yet locked", dll_locked, 0);
        step();
        check("R4 locked on time", dll_locked, 1);
        odt_cmd = 1; step(); idle();
        check("R6 odt after lock", early_cmd_viol, 0);

        // R4: relock on last cycle of window
        dll_rst_cmd = 1; step(); idle();
        repeat (T - 1) step();
        check("R4 one cycle before lock", dll_locked, 0);
        dll_rst_cmd = 1; step(); idle();
        check("R4 restart on last cycle", dll_locked, 0);
        repeat (T - 1) step();
        check("R4 still locking after restart", dll_locked, 0);
        step();
        check("R4 locked after restart", dll_locked, 1);

        // R5: all three strobes -> self-refresh wins
        sref_enter = 1; mr1_wr = 1; mr1_dll_dis = 1; dll_rst_cmd = 1; step(); idle();
        check("R5 sref wins dll_on", dll_on, 0);
        mr1_wr = 1; step(); idle();
        check("R3 mr1 ignored in sref", dll_on, 0);
        sref_exit = 1; step(); idle();
        check("R3 sref exit relocks", dll_on, 1);
        check("R3 sref exit unlocked", dll_locked, 0);
        // R5: MR1 disable beats DLL reset
        mr1_wr = 1; mr1_dll_dis = 1; dll_rst_cmd = 1; step(); idle();
        check("R5 mr1 beats reset", dll_on, 0);

        // R9: saturation
        mr1_wr = 1; step(); idle();
        for (int i = 0; i < 20; i++) begin rd_cmd = 1; step(); end
        idle(); step();
        check("R9 saturated", viol_count, MAXC);
        // R8: cke drop
        cke = 0; step(); idle();
        check("R8 cke low sets", cke_drop_err, 1);
        repeat (5) step();
        check("R8 sticky", cke_drop_err, 1);
        do_reset();
        check("R8 cleared by reset", cke_drop_err, 0);
        cke = 0; step(); idle();
        check("R8 cke low in off", cke_drop_err, 0);

        // random phase
        for (int n = 0; n < 4000; n++) begin
            if (n % 1000 == 999) do_reset();
            mr1_wr      = ($urandom_range(99) < 4);
            mr1_dll_dis = $urandom_range(1);
            dll_rst_cmd = ($urandom_range(99) < 3);
            sref_enter  = ($urandom_range(99) < 2);
            sref_exit   = ($urandom_range(99) < 10);
            rd_cmd      = ($urandom_range(99) < 8);
            odt_cmd     = ($urandom_range(99) < 4);
            wr_cmd      = ($urandom_range(99) < 8);
            rtt_wr_sel  = 2'($urandom_range(3));
            cke         = ($urandom_range(999) < 995);
            step();
        end
        idle();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule